// File: doc/BRIEF.md
# Byte-Wide Configuration Stream Sequencer

This block loads a target device with a fixed-length stream of configuration bytes. After reset it pulls a shared open-drain status line low for a hold-off period so that supplies can settle. A one-bit input picks a short or a long period. It then lets go of the line and waits until the line actually reads high. Any other agent on the wire can stretch the power-on phase by holding the line low.

Once the line is high, bytes are taken from a valid/ready source and presented on a parallel data bus. A configuration clock is derived from the system clock. The bus changes only as that clock falls, so the target can capture each byte on the rising edge. The clock parks high whenever the source has nothing to offer. If the status line drops during the stream, the transfer is abandoned and starts again from byte zero.

After the last byte and a fixed number of further cycles, the target's completion input is examined. A high value means success. A low value raises an error and sends a reconfiguration request on an open-drain output. The same request can also be raised on demand through a trigger input.

Top module: `cfg_stream_seq`

## Requirements
- R1: While reset is applied: `oe_drive_low`=1, `cfg_clk`=1, and `busy`, `done`, `error` and `reconf_drive_low` are all 0.
- R2: After reset is released, `oe_drive_low` stays 1 for exactly SHORT_CYC cycles when `long_sel`=0, or for exactly LONG_CYC cycles when `long_sel`=1. It then goes to 0.
- R3: `cfg_clk` never falls while the status line `oe_in` is low. While an external agent keeps the line low after the hold-off, `cfg_clk` stays 1 and `busy` stays 0.
- R4: `cfg_data` changes only in the cycle in which `cfg_clk` falls. The bytes seen at the rising edges of `cfg_clk` are the source bytes in order.
- R5: While `src_valid` is 0, `cfg_clk` does not fall, and it settles at 1 within HALF_CYC cycles. No byte is lost across the gap.
- R6: If `oe_in` goes low during a transfer, `busy` drops, `cfg_clk` returns to 1 and stays there, and the byte count restarts. Once the line is high again, the stream starts over from the first byte.
- R7: NUM_BYTES rising edges of `cfg_clk`, plus EXTRA_CYC cycles, end the transfer. If `ncs_in`=1 at that point, `done` becomes 1 and `busy` becomes 0.
- R8: If `ncs_in`=0 at that point, `error` becomes 1 and `reconf_drive_low` rises in the same cycle.
- R9: A cycle with `reconf_trig`=1 makes `reconf_drive_low` 1 for exactly PULSE_CYC cycles, starting in the next cycle. A trigger that coincides with an error yields one pulse of the same length.
- R10: `busy` is 1 while bytes are being sent and while the final check is pending. It is never 1 while `oe_drive_low` is 1.
- R11: From the done state, a low `oe_in` clears `done` within one cycle. A later high line starts a fresh stream, which can complete again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| long_sel | input | 1 | 1 selects the long hold-off period, 0 the short one |
| src_data | input | DATA_W | Byte offered by the source |
| src_valid | input | 1 | Source has a byte |
| src_ready | output | 1 | Byte taken at this clock edge when valid |
| cfg_data | output | DATA_W | Parallel configuration data to the target |
| cfg_clk | output | 1 | Generated configuration clock, idle high |
| oe_in | input | 1 | Level read back from the shared open-drain status line |
| oe_drive_low | output | 1 | 1 pulls the shared status line low |
| ncs_in | input | 1 | Target completion / select input |
| reconf_trig | input | 1 | Request a reconfiguration pulse |
| reconf_drive_low | output | 1 | 1 pulls the open-drain reconfiguration line low |
| busy | output | 1 | Transfer or final check in progress (registered) |
| done | output | 1 | Stream accepted by the target (registered) |
| error | output | 1 | Target did not report completion (registered) |

## Verification
Two functions can start the reconfiguration pulse in the same clock edge: the error decision at the end of the check window, and an external trigger. The bench waits for the final rising edge of `cfg_clk` and holds `ncs_in` low. It then counts EXTRA_CYC system clocks and raises `reconf_trig` so that it is sampled in exactly the cycle in which the error is decided. The result is judged by `error` reading 1 and by the request line staying low for exactly PULSE_CYC cycles: neither a doubled pulse nor a truncated one is accepted.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
   typedef enum logic [2:0] {
      ST_HOLD  = 3'd0,
      ST_WAIT  = 3'd1,
      ST_XFER  = 3'd2,
      ST_CHECK = 3'd3,
      ST_DONE  = 3'd4
   } seq_st_e;
endpackage

// File: rtl/cfg_holdoff_tmr.sv
module cfg_holdoff_tmr #(
   parameter int unsigned SHORT_CYC = 20,
   parameter int unsigned LONG_CYC  = 60
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic long_sel,
   output logic expire_o
);
   localparam int unsigned MAX_CYC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
   localparam int unsigned TW      = $clog2(MAX_CYC + 1);

   logic [TW-1:0] cnt_q;
   logic [TW-1:0] limit;

   generate
      if (SHORT_CYC == LONG_CYC) begin : g_fixed
         assign limit = TW'(SHORT_CYC - 1);
      end else begin : g_sel
         assign limit = long_sel ? TW'(LONG_CYC - 1) : TW'(SHORT_CYC - 1);
      end
   endgenerate

   // ">=" keeps the timer finite if the selection shrinks mid-count
   assign expire_o = en && (cnt_q >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (en && !expire_o) begin
         cnt_q <= cnt_q + TW'(1);
      end
   end
endmodule

// File: rtl/cfg_dclk_gen.sv
module cfg_dclk_gen #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned HALF_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [DATA_W-1:0] src_data,
   input  logic              src_valid,
   output logic              src_ready,
   output logic              dclk_o,
   output logic [DATA_W-1:0] data_o,
   output logic              rise_o
);
   localparam int unsigned CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
   localparam logic [CW-1:0] PH_END = CW'(HALF_CYC - 1);

   logic [CW-1:0]     ph_q;
   logic              dclk_q;
   logic [DATA_W-1:0] data_q;
   logic              ph_end;
   logic              take;

   assign ph_end    = (ph_q == PH_END);
   assign src_ready = run && dclk_q && ph_end;
   assign take      = src_ready && src_valid;
   assign rise_o    = run && !dclk_q && ph_end;
   assign dclk_o    = dclk_q;
   assign data_o    = data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dclk_q <= 1'b1;
         ph_q   <= '0;
         data_q <= '0;
      end else if (!run) begin
         dclk_q <= 1'b1;
         ph_q   <= '0;
      end else if (take) begin
         dclk_q <= 1'b0;
         data_q <= src_data;
         ph_q   <= '0;
      end else if (rise_o) begin
         dclk_q <= 1'b1;
         ph_q   <= '0;
      end else if (!ph_end) begin
         ph_q <= ph_q + CW'(1);
      end
   end
endmodule

// File: rtl/cfg_req_pulse.sv
module cfg_req_pulse #(
   parameter int unsigned PULSE_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic req_o
);
   logic req_q;
   assign req_o = req_q;

   generate
      if (PULSE_CYC == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) req_q <= 1'b0;
            else        req_q <= fire;
         end
      end else begin : g_count
         localparam int unsigned PW = $clog2(PULSE_CYC);
         logic [PW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               req_q <= 1'b0;
               cnt_q <= '0;
            end else if (fire) begin
               req_q <= 1'b1;
               cnt_q <= '0;
            end else if (req_q) begin
               if (cnt_q == PW'(PULSE_CYC - 1)) req_q <= 1'b0;
               else                             cnt_q <= cnt_q + PW'(1);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/cfg_stream_seq.sv
module cfg_stream_seq
   import cfg_seq_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned NUM_BYTES = 4,
   parameter int unsigned HALF_CYC  = 2,
   parameter int unsigned EXTRA_CYC = 3,
   parameter int unsigned SHORT_CYC = 20,
   parameter int unsigned LONG_CYC  = 60,
   parameter int unsigned PULSE_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              long_sel,
   input  logic [DATA_W-1:0] src_data,
   input  logic              src_valid,
   output logic              src_ready,
   output logic [DATA_W-1:0] cfg_data,
   output logic              cfg_clk,
   input  logic              oe_in,
   output logic              oe_drive_low,
   input  logic              ncs_in,
   input  logic              reconf_trig,
   output logic              reconf_drive_low,
   output logic              busy,
   output logic              done,
   output logic              error
);
   localparam int unsigned BCW = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;
   localparam int unsigned ECW = (EXTRA_CYC > 1) ? $clog2(EXTRA_CYC) : 1;

   if (DATA_W < 1)     begin : g_bad_width  $error("DATA_W must be at least 1");      end
   if (NUM_BYTES < 1)  begin : g_bad_bytes  $error("NUM_BYTES must be at least 1");   end
   if (HALF_CYC < 1)   begin : g_bad_half   $error("HALF_CYC must be at least 1");    end
   if (EXTRA_CYC < 1)  begin : g_bad_extra  $error("EXTRA_CYC must be at least 1");   end
   if (SHORT_CYC < 1)  begin : g_bad_short  $error("SHORT_CYC must be at least 1");   end
   if (LONG_CYC < 1)   begin : g_bad_long   $error("LONG_CYC must be at least 1");    end
   if (PULSE_CYC < 1)  begin : g_bad_pulse  $error("PULSE_CYC must be at least 1");   end

   seq_st_e        st_q, st_d;
   logic [BCW-1:0] bcnt_q;
   logic [ECW-1:0] ecnt_q;
   logic           hold_exp;
   logic           run;
   logic           bit_rise;
   logic           last_byte;
   logic           chk_end;
   logic           err_ev;

   assign oe_drive_low = (st_q == ST_HOLD);
   assign run          = (st_q == ST_XFER) && oe_in;
   assign last_byte    = (bcnt_q == BCW'(NUM_BYTES - 1));
   assign chk_end      = (ecnt_q == ECW'(EXTRA_CYC - 1));
   assign err_ev       = (st_q == ST_CHECK) && oe_in && chk_end && !ncs_in;

   cfg_holdoff_tmr #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (st_q == ST_HOLD),
      .long_sel (long_sel),
      .expire_o (hold_exp)
   );

   cfg_dclk_gen #(.DATA_W(DATA_W), .HALF_CYC(HALF_CYC)) u_dclk (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .src_data  (src_data),
      .src_valid (src_valid),
      .src_ready (src_ready),
      .dclk_o    (cfg_clk),
      .data_o    (cfg_data),
      .rise_o    (bit_rise)
   );

   cfg_req_pulse #(.PULSE_CYC(PULSE_CYC)) u_req (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (reconf_trig || err_ev),
      .req_o (reconf_drive_low)
   );

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_HOLD:  if (hold_exp) st_d = ST_WAIT;
         ST_WAIT:  if (oe_in) st_d = ST_XFER;
         ST_XFER: begin
            if (!oe_in)                     st_d = ST_WAIT;
            else if (bit_rise && last_byte) st_d = ST_CHECK;
         end
         ST_CHECK: begin
            if (!oe_in)       st_d = ST_WAIT;
            else if (chk_end) st_d = ncs_in ? ST_DONE : ST_WAIT;
         end
         ST_DONE:  if (!oe_in) st_d = ST_WAIT;
         default:  st_d = ST_HOLD;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_HOLD;
         bcnt_q <= '0;
         ecnt_q <= '0;
         busy   <= 1'b0;
         done   <= 1'b0;
         error  <= 1'b0;
      end else begin
         st_q <= st_d;
         busy <= (st_d == ST_XFER) || (st_d == ST_CHECK);
         done <= (st_d == ST_DONE);

         if (st_q != ST_XFER) bcnt_q <= '0;
         else if (bit_rise)   bcnt_q <= bcnt_q + BCW'(1);

         if (st_q != ST_CHECK) ecnt_q <= '0;
         else if (!chk_end)    ecnt_q <= ecnt_q + ECW'(1);

         if (err_ev)                error <= 1'b1;
         else if (st_d == ST_DONE)  error <= 1'b0;
      end
   end
endmodule

// File: rtl/cfg_stream_seq_chk.sv
module cfg_stream_seq_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              src_valid,
   input logic [DATA_W-1:0] cfg_data,
   input logic              cfg_clk,
   input logic              oe_in,
   input logic              oe_drive_low,
   input logic              reconf_trig,
   input logic              reconf_drive_low,
   input logic              busy,
   input logic              done,
   input logic              error
);
   // R4
   data_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_data) |-> $fell(cfg_clk));

   // R3
   line_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cfg_clk) |-> $past(oe_in));

   // R5
   src_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !src_valid |=> !$fell(cfg_clk));

   // R9
   trig_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reconf_trig |=> reconf_drive_low);

   // R8
   err_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(error) |-> reconf_drive_low);

   // R10
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !oe_drive_low);

   // R7
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !error));
endmodule

bind cfg_stream_seq cfg_stream_seq_chk #(.DATA_W(DATA_W)) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .src_valid        (src_valid),
   .cfg_data         (cfg_data),
   .cfg_clk          (cfg_clk),
   .oe_in            (oe_in),
   .oe_drive_low     (oe_drive_low),
   .reconf_trig      (reconf_trig),
   .reconf_drive_low (reconf_drive_low),
   .busy             (busy),
   .done             (done),
   .error            (error)
);

// File: tb/sim_cfg_stream_seq.sv
`timescale 1ns/1ps
module sim_cfg_stream_seq;
   localparam int DW    = 8;
   localparam int NB    = 4;
   localparam int HALF  = 2;
   localparam int EXTRA = 3;
   localparam int SHORT = 20;
   localparam int LONG  = 60;
   localparam int PULSE = 4;

   // {long_sel, ncs at end, gap[5:0], external hold[7:0]}
   localparam logic [15:0] VEC [4] = '{16'h4000, 16'hC60A, 16'h0005, 16'h8600};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          long_sel = 1'b0;
   logic          src_on = 1'b1;
   logic          tgt_oe_low = 1'b0;
   logic          ncs = 1'b0;
   logic          reconf_trig = 1'b0;
   logic [7:0]    seed = 8'h00;
   int            idx = 0;
   int            rx_n = 0;
   int            falls = 0;
   logic [DW-1:0] rx [16];
   int            n_chk = 0;
   int            n_err = 0;

   logic          src_valid, src_ready, cfg_clk, oe_in, oe_drive_low;
   logic          reconf_drive_low, busy, done, error;
   logic [DW-1:0] src_data, cfg_data;

   assign oe_in     = !(oe_drive_low || tgt_oe_low);
   assign src_valid = src_on && (idx < NB);
   assign src_data  = seed ^ 8'(idx * 37 + 5);

   cfg_stream_seq #(
      .DATA_W(DW), .NUM_BYTES(NB), .HALF_CYC(HALF), .EXTRA_CYC(EXTRA),
      .SHORT_CYC(SHORT), .LONG_CYC(LONG), .PULSE_CYC(PULSE)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .long_sel(long_sel),
      .src_data(src_data), .src_valid(src_valid), .src_ready(src_ready),
      .cfg_data(cfg_data), .cfg_clk(cfg_clk),
      .oe_in(oe_in), .oe_drive_low(oe_drive_low), .ncs_in(ncs),
      .reconf_trig(reconf_trig), .reconf_drive_low(reconf_drive_low),
      .busy(busy), .done(done), .error(error)
   );

   initial forever #2.5 clk = ~clk;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // source index and data-edge monitor, sampled between edges
   initial begin
      logic          pdclk;
      logic [DW-1:0] pdata;
      pdclk = 1'b1;
      pdata = '0;
      forever begin
         @(negedge clk);
         if (pdclk && !cfg_clk) begin
            idx++;
            falls++;
         end else if (rst_n && cfg_data != pdata) begin
            chk(1'b0, "R4 data moved without falling clock", int'(cfg_data), int'(pdata));
         end
         pdclk = cfg_clk;
         pdata = cfg_data;
      end
   end

   // target-side capture at the rising configuration clock
   initial forever begin
      @(posedge cfg_clk);
      if (oe_in && rst_n && rx_n < 16) begin
         rx[rx_n] = cfg_data;
         rx_n++;
      end
   end

   task automatic do_reset(input logic lsel, input logic hold_line);
      rst_n = 1'b0;
      long_sel = lsel;
      tgt_oe_low = hold_line;
      ncs = 1'b0;
      src_on = 1'b1;
      reconf_trig = 1'b0;
      repeat (3) @(negedge clk);
      idx = 0;
      rx_n = 0;
      rst_n = 1'b1;
   endtask

   task automatic wait_hold(output int cyc);
      cyc = 0;
      while (oe_drive_low && cyc < 1000) begin
         cyc++;
         @(negedge clk);
      end
   endtask

   task automatic wait_rx(input int n);
      int g;
      g = 0;
      while (rx_n < n && g < 5000) begin
         g++;
         @(negedge clk);
      end
   endtask

   function automatic int bad_bytes();
      int b;
      b = 0;
      for (int i = 0; i < NB; i++)
         if (rx[i] !== (seed ^ 8'(i * 37 + 5))) b++;
      return b;
   endfunction

   task automatic pulse_len(output int n);
      n = 0;
      while (reconf_drive_low && n < 50) begin
         n++;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      chk(1'b0, "watchdog (run did not finish)", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      int hc, pl;
      // R1: state while reset is held
      repeat (3) @(negedge clk);
      chk(oe_drive_low == 1'b1, "R1 oe_drive_low in reset", oe_drive_low, 1);
      chk(cfg_clk == 1'b1, "R1 cfg_clk in reset", cfg_clk, 1);
      chk({busy, done, error, reconf_drive_low} == 4'b0, "R1 status in reset",
          {busy, done, error, reconf_drive_low}, 0);

      // table-driven runs
      for (int v = 0; v < 4; v++) begin
         logic       vl, vn;
         int         vg, ve;
         vl = VEC[v][15];
         vn = VEC[v][14];
         vg = int'(VEC[v][13:8]);
         ve = int'(VEC[v][7:0]);
         seed = 8'(v * 71 + 19);
         do_reset(vl, ve != 0);
         wait_hold(hc);
         chk(hc == (vl ? LONG : SHORT), "R2 hold-off length", hc, vl ? LONG : SHORT);
         if (ve != 0) begin
            falls = 0;
            repeat (ve) @(negedge clk);
            chk(falls == 0 && cfg_clk && !busy, "R3 line held low externally", falls, 0);
            tgt_oe_low = 1'b0;
         end
         wait_rx(1);
         @(negedge clk);
         chk(busy == 1'b1, "R10 busy during stream", busy, 1);
         if (vg != 0) begin
            src_on = 1'b0;
            falls = 0;
            repeat (vg) @(negedge clk);
            chk(falls == 0 && cfg_clk == 1'b1, "R5 clock parked high on empty source", falls, 0);
            src_on = 1'b1;
         end
         wait_rx(NB);
         @(negedge clk);
         ncs = vn;
         repeat (EXTRA + 2) @(negedge clk);
         chk(bad_bytes() == 0 && rx_n == NB, "R4 byte order at rising edge", bad_bytes(), 0);
         chk(done == vn, "R7 done after check window", done, vn);
         chk(error == !vn, "R8 error on missing completion", error, !vn);
         if (vn) chk(busy == 1'b0, "R10 busy low after completion", busy, 0);
         else    chk(reconf_drive_low == 1'b1, "R8 retry request raised", reconf_drive_low, 1);
      end

      // R6: abort mid-stream and restart from byte zero
      seed = 8'hA5;
      do_reset(1'b0, 1'b0);
      wait_hold(hc);
      wait_rx(2);
      @(negedge clk);
      tgt_oe_low = 1'b1;
      ncs = 1'b0;
      repeat (2) @(negedge clk);
      chk(busy == 1'b0 && cfg_clk == 1'b1, "R6 abort drops busy and parks clock", busy, 0);
      falls = 0;
      repeat (5) @(negedge clk);
      chk(falls == 0, "R6 no clock while line low", falls, 0);
      idx = 0;
      rx_n = 0;
      tgt_oe_low = 1'b0;
      wait_rx(NB);
      @(negedge clk);
      ncs = 1'b1;
      repeat (EXTRA + 2) @(negedge clk);
      chk(bad_bytes() == 0 && rx_n == NB, "R6 restarted stream from first byte", bad_bytes(), 0);
      chk(done == 1'b1, "R6 restarted stream completes", done, 1);

      // R11: target restart from the done state
      tgt_oe_low = 1'b1;
      ncs = 1'b0;
      @(negedge clk);
      chk(done == 1'b0, "R11 done cleared by line low", done, 0);
      idx = 0;
      rx_n = 0;
      @(negedge clk);
      tgt_oe_low = 1'b0;
      wait_rx(NB);
      @(negedge clk);
      ncs = 1'b1;
      repeat (EXTRA + 2) @(negedge clk);
      chk(done == 1'b1 && bad_bytes() == 0, "R11 second stream completes", done, 1);

      // R9: on-demand request pulse
      reconf_trig = 1'b1;
      @(negedge clk);
      reconf_trig = 1'b0;
      pulse_len(pl);
      chk(pl == PULSE, "R9 request pulse length", pl, PULSE);

      // R9 with R8: trigger sampled in the error-decision cycle
      seed = 8'h3C;
      do_reset(1'b0, 1'b0);
      wait_hold(hc);
      wait_rx(NB - 1);
      @(posedge cfg_clk);
      repeat (EXTRA - 1) @(posedge clk);
      @(negedge clk);
      reconf_trig = 1'b1;
      @(negedge clk);
      reconf_trig = 1'b0;
      chk(error == 1'b1, "R8 error with coinciding trigger", error, 1);
      pulse_len(pl);
      chk(pl == PULSE, "R9 single pulse when trigger meets error", pl, PULSE);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule